// File: doc/BRIEF.md
# Steered Replicated Control Register Bank

The bank keeps one copy of a small set of control registers for every hardware unit in a cluster. All copies of a given register answer at one shared offset on a simple synchronous register bus. Which copy is reached, and whether a write reaches one copy or all of them, is set by a separate selector register. The selector carries a broadcast flag and a unit index.

Writes are either broadcast to every unit or aimed at the unit that the index names. Reads always return the copy of the indexed unit, even when the broadcast flag is set. An access aimed at a unit that is fused off, power-gated, or beyond the implemented unit count is terminated:
- a terminated read yields zero;
- a terminated unicast write vanishes without trace.

Every copy is also driven out on a flat bus, so that the units themselves can consume their settings.

Top module: `rep_reg_bank`

## Requirements
- R1: After reset the selector reads 0 (broadcast off, unit index 0), every copy in `unit_regs` is zero and `rd_data` is zero.
- R2: Offsets 0 to NUM_REGS-1 are the replicated registers and offset NUM_REGS is the selector. In the selector, bit 31 is the broadcast flag and bits STEER_W-1:0 are the unit index. A selector read returns those fields with all other bits zero.
- R3: With broadcast set, a write to a replicated offset loads the same value into that register of every live unit on the next clock edge.
- R4: With broadcast clear, a write to a replicated offset changes only the indexed unit's copy.
- R5: A read takes effect one cycle after `rd_en`. A read of a replicated offset returns the indexed unit's copy whatever the broadcast flag is. `rd_data` holds its value in cycles without `rd_en`.
- R6: A read of a replicated offset aimed at a unit whose `fuse_off` or `pwr_gated` bit is set in the access cycle returns zero.
- R7: A unicast write aimed at a fused-off or power-gated unit leaves every copy unchanged.
- R8: A broadcast write skips units that are fused off or power-gated in the access cycle and updates all the other units.
- R9: A unit index at or above NUM_UNITS terminates the access: replicated reads return zero and unicast writes change nothing.
- R10: A read and a write to the same copy in the same cycle return the value held before the write.
- R11: A power-gated unit keeps its contents and shows them again once the gate is lifted.
- R12: Offsets above NUM_REGS read as zero, and writes to them change neither the selector nor any copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write value |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read value |
| fuse_off | input | NUM_UNITS | Per-unit fused-off flags |
| pwr_gated | input | NUM_UNITS | Per-unit power-gated flags |
| unit_regs | output | NUM_UNITS*NUM_REGS*DATA_W | All copies; unit u, register r at bits ((u*NUM_REGS)+r)*DATA_W upward |

## Verification
Two things can happen in the same cycle: a read and a write to the same copy, and a change in a unit's fuse or power-gate flag together with an access aimed at that unit.
- The bench issues `rd_en` and `wr_en` together on one replicated offset. It expects the value from before the write, then reads again and expects the new value.
- The bench raises `pwr_gated` or `fuse_off` in the very cycle of a broadcast or unicast write. It checks that only that unit's copies stay frozen, and that they reappear when the flag drops.

Random traffic with random masks keeps hitting these overlaps. Its outcomes are judged against a reference model of the copies kept in the bench.

// File: rtl/rep_reg_bank_pkg.sv
package rep_reg_bank_pkg;
  // Position of the broadcast flag inside the selector word.
  localparam int unsigned BCAST_BIT = 31;

  // Kind of target an access offset decodes to.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_REP  = 2'd1,
    ACC_SEL  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/rrb_selector.sv
module rrb_selector #(
  parameter int unsigned STEER_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               bcast_in,
  input  logic [STEER_W-1:0] idx_in,
  output logic               bcast_o,
  output logic [STEER_W-1:0] idx_o
);
  logic               bcast_d;
  logic [STEER_W-1:0] idx_d;

  always_comb begin
    bcast_d = bcast_o;
    idx_d   = idx_o;
    if (load) begin
      bcast_d = bcast_in;
      idx_d   = idx_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcast_o <= 1'b0;
      idx_o   <= '0;
    end else begin
      bcast_o <= bcast_d;
      idx_o   <= idx_d;
    end
  end
endmodule

// File: rtl/rrb_unit_copy.sv
module rrb_unit_copy #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned RIDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [RIDX_W-1:0]          widx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic              ld;
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;

    assign ld = wr_en && (widx == RIDX_W'(r));

    always_comb begin
      d = q;
      if (ld) d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign regs_o[r*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/rrb_read_path.sv
module rrb_read_path
  import rep_reg_bank_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 6,
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned STEER_W   = 3,
  localparam int unsigned RIDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned ALL_W    = NUM_UNITS * NUM_REGS * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  acc_kind_e          kind,
  input  logic [RIDX_W-1:0]  ridx,
  input  logic               bcast,
  input  logic [STEER_W-1:0] idx,
  input  logic [NUM_UNITS-1:0] live,
  input  logic [ALL_W-1:0]   all_regs,
  output logic [DATA_W-1:0]  rd_data
);
  logic [DATA_W-1:0] picked;
  logic              hit;
  logic [DATA_W-1:0] sel_word;
  logic [DATA_W-1:0] rd_d;

  // Choose the steered copy; an index with no matching unit leaves hit low.
  always_comb begin
    picked = '0;
    hit    = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (idx == STEER_W'(u)) begin
        hit    = live[u];
        picked = all_regs[(u*NUM_REGS + int'(ridx))*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    sel_word                   = '0;
    sel_word[BCAST_BIT]        = bcast;
    sel_word[STEER_W-1:0]      = idx;
  end

  always_comb begin
    rd_d = rd_data;
    if (rd_en) begin
      unique case (kind)
        ACC_SEL: rd_d = sel_word;
        ACC_REP: rd_d = hit ? picked : '0;
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end
endmodule

// File: rtl/rep_reg_bank.sv
module rep_reg_bank
  import rep_reg_bank_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 6,
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned STEER_W   = 3,
  localparam int unsigned RIDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned ALL_W    = NUM_UNITS * NUM_REGS * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_en,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [NUM_UNITS-1:0] fuse_off,
  input  logic [NUM_UNITS-1:0] pwr_gated,
  output logic [ALL_W-1:0]     unit_regs
);
  acc_kind_e            kind;
  logic [RIDX_W-1:0]    ridx;
  logic                 sel_mc;
  logic [STEER_W-1:0]   sel_idx;
  logic [NUM_UNITS-1:0] live;
  logic [NUM_UNITS-1:0] unit_we;

  // Offset decode: replicated block first, selector right after it.
  always_comb begin
    if (addr < ADDR_W'(NUM_REGS))       kind = ACC_REP;
    else if (addr == ADDR_W'(NUM_REGS)) kind = ACC_SEL;
    else                                kind = ACC_NONE;
    ridx = RIDX_W'(addr);
  end

  assign live = ~(fuse_off | pwr_gated);

  rrb_selector #(.STEER_W(STEER_W)) sel_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_en && (kind == ACC_SEL)),
    .bcast_in (wr_data[BCAST_BIT]),
    .idx_in   (wr_data[STEER_W-1:0]),
    .bcast_o  (sel_mc),
    .idx_o    (sel_idx)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic aimed;
    assign aimed      = sel_mc || (sel_idx == STEER_W'(u));
    assign unit_we[u] = wr_en && (kind == ACC_REP) && aimed && live[u];

    rrb_unit_copy #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) copy_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (unit_we[u]),
      .widx   (ridx),
      .wdata  (wr_data),
      .regs_o (unit_regs[u*NUM_REGS*DATA_W +: NUM_REGS*DATA_W])
    );
  end

  rrb_read_path #(
    .NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS),
    .DATA_W(DATA_W), .STEER_W(STEER_W)
  ) rd_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .kind     (kind),
    .ridx     (ridx),
    .bcast    (sel_mc),
    .idx      (sel_idx),
    .live     (live),
    .all_regs (unit_regs),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/rep_reg_bank_chk.sv
module rep_reg_bank_chk #(
  parameter int unsigned NUM_UNITS = 6,
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned STEER_W   = 3,
  localparam int unsigned ALL_W    = NUM_UNITS * NUM_REGS * DATA_W,
  localparam int unsigned UNIT_W   = NUM_REGS * DATA_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    addr,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [DATA_W-1:0]    rd_data,
  input logic [NUM_UNITS-1:0] fuse_off,
  input logic [NUM_UNITS-1:0] pwr_gated,
  input logic [ALL_W-1:0]     unit_regs,
  input logic                 mc,
  input logic [STEER_W-1:0]   steer
);
  logic [ALL_W-1:0]     prev_regs;
  logic [NUM_UNITS-1:0] changed;
  logic [NUM_UNITS-1:0] dead;
  logic                 rep_acc;
  logic                 aimed_dead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_regs <= '0;
    else        prev_regs <= unit_regs;
  end

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++)
      changed[u] = unit_regs[u*UNIT_W +: UNIT_W] != prev_regs[u*UNIT_W +: UNIT_W];
  end

  assign dead    = fuse_off | pwr_gated;
  assign rep_acc = addr < ADDR_W'(NUM_REGS);

  always_comb begin
    aimed_dead = 1'b1;
    for (int u = 0; u < NUM_UNITS; u++)
      if (steer == STEER_W'(u)) aimed_dead = dead[u];
  end

  // R4: a unicast write touches at most one unit.
  assert_unicast_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && rep_acc && !mc)) |-> ($countones(changed) <= 1));

  // R7 / R8: units dead during the write cycle never change.
  assert_dead_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en)) |-> ((changed & $past(dead)) == '0));

  // R12: no write, no change in any copy.
  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en)) |-> (changed == '0));

  // R6 / R9: terminated replicated read yields zero.
  assert_term_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en && rep_acc && aimed_dead)) |-> (rd_data == '0));

  // R5: read data is held when no read is issued.
  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rd_en)) |-> $stable(rd_data));
endmodule

bind rep_reg_bank rep_reg_bank_chk #(
  .NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
  .ADDR_W(ADDR_W), .STEER_W(STEER_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .fuse_off  (fuse_off),
  .pwr_gated (pwr_gated),
  .unit_regs (unit_regs),
  .mc        (sel_mc),
  .steer     (sel_idx)
);

// File: tb/rep_reg_bank_tb_top.sv
module rep_reg_bank_tb_top;
  localparam int NU = 6;
  localparam int NR = 4;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int SW = 3;
  localparam int SELA = NR;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [AW-1:0]       addr;
  logic                wr_en;
  logic [DW-1:0]       wr_data;
  logic                rd_en;
  logic [DW-1:0]       rd_data;
  logic [NU-1:0]       fuse_off;
  logic [NU-1:0]       pwr_gated;
  logic [NU*NR*DW-1:0] unit_regs;

  always #10 clk = ~clk;

  rep_reg_bank #(.NUM_UNITS(NU), .NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW), .STEER_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .fuse_off(fuse_off), .pwr_gated(pwr_gated),
    .unit_regs(unit_regs));

  // Reference model
  logic [DW-1:0] mdl [NU][NR];
  logic          m_mc;
  logic [SW-1:0] m_idx;
  logic [DW-1:0] m_rd;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit is_live(int u, logic [NU-1:0] f, logic [NU-1:0] p);
    return !(f[u] || p[u]);
  endfunction

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a, logic [NU-1:0] f, logic [NU-1:0] p);
    logic [DW-1:0] w;
    w = '0;
    if (int'(a) == SELA) begin
      w[31] = m_mc;
      w[SW-1:0] = m_idx;
    end else if (int'(a) < NR) begin
      if (int'(m_idx) < NU && is_live(int'(m_idx), f, p)) w = mdl[int'(m_idx)][int'(a)];
    end
    return w;
  endfunction

  task automatic model_write(logic [AW-1:0] a, logic [DW-1:0] d, logic [NU-1:0] f, logic [NU-1:0] p);
    if (int'(a) == SELA) begin
      m_mc  = d[31];
      m_idx = d[SW-1:0];
    end else if (int'(a) < NR) begin
      for (int u = 0; u < NU; u++)
        if ((m_mc || int'(m_idx) == u) && is_live(u, f, p)) mdl[u][int'(a)] = d;
    end
  endtask

  // One bus cycle; called at a negedge, returns at the following negedge.
  task automatic op(bit w, bit r, logic [AW-1:0] a, logic [DW-1:0] d,
                    logic [NU-1:0] f, logic [NU-1:0] p, string tag);
    logic [DW-1:0] e;
    addr = a; wr_en = w; rd_en = r; wr_data = d; fuse_off = f; pwr_gated = p;
    if (r) m_rd = exp_read(a, f, p);
    e = m_rd;
    @(posedge clk);
    if (w) model_write(a, d, f, p);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    if (r) check(tag, rd_data, e);
  endtask

  task automatic check_copies(string tag);
    for (int u = 0; u < NU; u++)
      for (int k = 0; k < NR; k++)
        check(tag, unit_regs[(u*NR+k)*DW +: DW], mdl[u][k]);
  endtask

  localparam logic [NU-1:0] NONE = '0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; addr = '0; wr_en = 0; rd_en = 0; wr_data = '0;
    fuse_off = '0; pwr_gated = '0;
    for (int u = 0; u < NU; u++) for (int k = 0; k < NR; k++) mdl[u][k] = '0;
    m_mc = 0; m_idx = '0; m_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 rd_data", rd_data, '0);
    check_copies("R1 copies");
    op(0, 1, AW'(SELA), '0, NONE, NONE, "R1 selector");

    // R2 selector fields
    op(1, 0, AW'(SELA), 32'h8000_0005, NONE, NONE, "R2");
    op(0, 1, AW'(SELA), '0, NONE, NONE, "R2 readback");
    op(1, 0, AW'(SELA), 32'h7FFF_FFF2, NONE, NONE, "R2");
    op(0, 1, AW'(SELA), '0, NONE, NONE, "R2 other bits zero");

    // R3 broadcast to all live units
    op(1, 0, AW'(SELA), 32'h8000_0000, NONE, NONE, "R3");
    op(1, 0, AW'(1), 32'hCAFE_0001, NONE, NONE, "R3");
    check_copies("R3 broadcast");

    // R4 unicast
    op(1, 0, AW'(SELA), 32'h0000_0003, NONE, NONE, "R4");
    op(1, 0, AW'(1), 32'h1234_5678, NONE, NONE, "R4");
    check_copies("R4 unicast");

    // R5 read steered copy with broadcast set, and hold
    op(1, 0, AW'(SELA), 32'h8000_0003, NONE, NONE, "R5");
    op(0, 1, AW'(1), '0, NONE, NONE, "R5 steered read");
    op(0, 0, AW'(0), '0, NONE, NONE, "R5 hold");
    check("R5 hold", rd_data, 32'h1234_5678);

    // R10 read+write same copy same cycle
    op(1, 0, AW'(SELA), 32'h0000_0002, NONE, NONE, "R10");
    op(1, 1, AW'(1), 32'h0BAD_BEEF, NONE, NONE, "R10 old value");
    op(0, 1, AW'(1), '0, NONE, NONE, "R10 new value");

    // R6 / R7 terminated to gated or fused unit
    op(0, 1, AW'(1), '0, NONE, 6'b000100, "R6 gated read zero");
    op(0, 1, AW'(1), '0, 6'b000100, NONE, "R6 fused read zero");
    op(1, 0, AW'(1), 32'h5555_5555, NONE, 6'b000100, "R7");
    op(1, 0, AW'(2), 32'h6666_6666, 6'b000100, NONE, "R7");
    check_copies("R7 dropped");

    // R8 broadcast skips dead units (flags raised in the write cycle)
    op(1, 0, AW'(SELA), 32'h8000_0002, NONE, NONE, "R8");
    op(1, 0, AW'(3), 32'hA5A5_0003, 6'b000001, 6'b100000, "R8");
    check_copies("R8 skip dead");

    // R11 retention across power gate
    op(1, 0, AW'(SELA), 32'h0000_0002, NONE, NONE, "R11");
    op(0, 1, AW'(1), '0, NONE, 6'b000100, "R11 gated");
    op(0, 1, AW'(1), '0, NONE, NONE, "R11 restored");

    // R9 index out of range
    op(1, 0, AW'(SELA), 32'h0000_0007, NONE, NONE, "R9");
    op(0, 1, AW'(1), '0, NONE, NONE, "R9 read zero");
    op(1, 0, AW'(0), 32'hDEAD_0000, NONE, NONE, "R9");
    check_copies("R9 write dropped");

    // R12 unmapped offsets
    op(1, 0, AW'(SELA+1), 32'hFFFF_FFFF, NONE, NONE, "R12");
    op(1, 0, AW'(7), 32'hFFFF_FFFF, NONE, NONE, "R12");
    op(0, 1, AW'(6), '0, NONE, NONE, "R12 read zero");
    op(0, 1, AW'(SELA), '0, NONE, NONE, "R12 selector kept");
    check_copies("R12 copies kept");

    // Random traffic
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [NU-1:0] f, p;
      bit w, r;
      a = AW'($urandom % 6);
      d = $urandom;
      if (a == AW'(SELA)) d = d & 32'h8000_0007;
      w = ($urandom % 3) != 0;
      r = ($urandom % 2) != 0;
      f = (($urandom % 4) == 0) ? NU'($urandom) : '0;
      p = (($urandom % 4) == 0) ? NU'($urandom) : '0;
      op(w, r, a, d, f, p, "R3/R4/R5/R6 random");
      if ((i % 50) == 49) check_copies("R8 random copies");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule